// File: doc/BRIEF.md
# PCI bridge parity error responder

This block judges bus parity on both sides of a two-port PCI-to-PCI bridge and decides how the bridge reacts to a parity fault. Each side presents its address/data bus, its command/byte-enable bus, a strobe that marks an address phase, a strobe that marks a write data phase aimed at the bridge, and the result of the external address decode. The PAR bit for a phase arrives on the clock after that phase. The check is made on that clock, using even parity across AD, C/BE# and PAR.

When an address phase has bad parity and that side's response enable is set, the block withholds the device-select claim, so the initiator ends with a master abort. Address faults can raise the primary system-error line, and write-data faults pulse that side's PERR#. Sticky detected-error and system-error flags record what happened. Software reads and writes the enables and flags through a small register port, and the flags are cleared by writing ones. The block does not recompute parity on data it forwards. The PAR bit of each side is sent on to the opposite side one clock later, so a far target sees the original fault.

Register map (address on `reg_addr`): 0 = command (bit 0 primary parity response enable, bit 1 system-error enable); 1 = bridge control (bit 0 secondary parity response enable); 2 = primary status (bit 0 detected parity error, bit 1 signaled system error, both write-one-to-clear); 3 = secondary status (bit 0 detected parity error, write-one-to-clear). Unused bits read zero.

Top module: `prb_parity_responder`

## Requirements
- R1: After reset, `pri_claim` and `sec_claim` are 0, `pri_perr_n`, `sec_perr_n` and `pri_serr_n` are 1, and all four registers read 0.
- R2: In the clock after a primary address phase, `pri_claim` is 1 exactly when the decode hit was set in that phase and it is not the case that the phase had a parity error (odd count of ones across AD, C/BE# and the next clock's PAR) while command bit 0 is set.
- R3: In the clock after a secondary address phase, `sec_claim` follows the same rule as R2, using bridge control bit 0 as the enable.
- R4: A parity error on a primary address or write data phase sets primary status bit 0, and one on the secondary side sets secondary status bit 0, whatever the enable bits say. The bit is readable two clocks after the phase.
- R5: A primary address parity error drives `pri_serr_n` low for exactly one clock, two clocks after the phase, and sets primary status bit 1, only if command bits 0 and 1 are both set.
- R6: A secondary address parity error does the same as R5 only if command bit 1 and bridge control bit 0 are both set. Faults on both sides in the same phase give a single one-clock pulse.
- R7: A write data phase with a parity error drives that side's PERR# low for one clock, two clocks after the phase, only if that side's enable is set (command bit 0 for primary, bridge control bit 0 for secondary). Address phases never drive PERR#.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a clear and a new error fall in the same clock, the bit ends up set.
- R9: A register write issued in the clock in which a data parity error is being detected still takes effect. The PERR# decision for that error uses the enable value held before the write.
- R10: `sec_par_out` equals `pri_par` of the previous clock, and `pri_par_out` equals `sec_par` of the previous clock, whether or not that parity is correct.
- R11: Bad parity on clocks with no address or write data phase strobe changes no status bit and drives no PERR# or SERR#.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pri_addr_phase | input | 1 | Primary address phase this clock |
| pri_wr_phase | input | 1 | Primary write data phase targeting the bridge this clock |
| pri_ad | input | AD_W | Primary address/data bus |
| pri_cbe_n | input | CBE_W | Primary command/byte-enable bus |
| pri_par | input | 1 | Primary PAR, covering the previous clock's phase |
| pri_dec_hit | input | 1 | Primary address decodes to or through the bridge |
| sec_addr_phase | input | 1 | Secondary address phase this clock |
| sec_wr_phase | input | 1 | Secondary write data phase targeting the bridge this clock |
| sec_ad | input | AD_W | Secondary address/data bus |
| sec_cbe_n | input | CBE_W | Secondary command/byte-enable bus |
| sec_par | input | 1 | Secondary PAR, covering the previous clock's phase |
| sec_dec_hit | input | 1 | Secondary address decodes to or through the bridge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | RD_W | Register write data |
| reg_rdata | output | RD_W | Register read data (combinational on reg_addr) |
| pri_claim | output | 1 | Permit to assert primary DEVSEL# |
| sec_claim | output | 1 | Permit to assert secondary DEVSEL# |
| pri_perr_n | output | 1 | Primary PERR#, active low |
| sec_perr_n | output | 1 | Secondary PERR#, active low |
| pri_serr_n | output | 1 | Primary SERR#, active low, open-drain style pulse |
| sec_par_out | output | 1 | Primary PAR carried to the secondary side |
| pri_par_out | output | 1 | Secondary PAR carried to the primary side |

## Verification
Two things can meet in one clock. A software write-one-to-clear can land on a status flag in the same clock that a fresh parity fault sets it. A register write can also update an enable in the same clock that a data fault is being judged against that enable. The bench provokes the first case by driving a primary address phase with bad parity and issuing a clear of the primary status register on the PAR clock. It expects both flags to read back set. It provokes the second case by rewriting the command register on the PAR clock of a faulty write. It expects PERR# to follow the old enable and the register to hold the new value. A third overlap, faulty address phases on both sides at once, must give one SERR# pulse of exactly one clock.

// File: rtl/prb_pkg.sv
package prb_pkg;

  localparam int NSIDE    = 2;
  localparam int SIDE_PRI = 0;
  localparam int SIDE_SEC = 1;
  localparam int REG_AW   = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_CMD   = 2'd0,
    RA_BCTL  = 2'd1,
    RA_PSTAT = 2'd2,
    RA_SSTAT = 2'd3
  } reg_addr_e;

  // bit positions inside the registers
  localparam int CMD_RESP_BIT  = 0;
  localparam int CMD_SERR_BIT  = 1;
  localparam int BCTL_RESP_BIT = 0;
  localparam int STAT_DET_BIT  = 0;
  localparam int STAT_SIG_BIT  = 1;

endpackage

// File: rtl/prb_side_check.sv
module prb_side_check #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_phase,
  input  logic             wr_phase,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe_n,
  input  logic             par,
  input  logic             dec_hit,
  input  logic             resp_en,
  output logic             addr_err,
  output logic             data_err,
  output logic             claim,
  output logic             par_fwd
);

  logic [AD_W-1:0]  ad_q,  ad_d;
  logic [CBE_W-1:0] cbe_q, cbe_d;
  logic addr_q, addr_d;
  logic wr_q,   wr_d;
  logic hit_q,  hit_d;
  logic par_q,  par_d;
  logic cap_en;
  logic odd;

  // next state
  always_comb begin
    cap_en = addr_phase | wr_phase;
    ad_d   = ad_q;
    cbe_d  = cbe_q;
    if (cap_en) begin
      ad_d  = ad;
      cbe_d = cbe_n;
    end
    addr_d = addr_phase;
    wr_d   = wr_phase & ~addr_phase;
    hit_d  = addr_phase & dec_hit;
    par_d  = par;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_q   <= '0;
      cbe_q  <= '0;
      addr_q <= 1'b0;
      wr_q   <= 1'b0;
      hit_q  <= 1'b0;
      par_q  <= 1'b0;
    end else begin
      ad_q   <= ad_d;
      cbe_q  <= cbe_d;
      addr_q <= addr_d;
      wr_q   <= wr_d;
      hit_q  <= hit_d;
      par_q  <= par_d;
    end
  end

  // even parity: the ones across captured bus plus current PAR must be even
  assign odd      = ^{ad_q, cbe_q, par};
  assign addr_err = addr_q & odd;
  assign data_err = wr_q & odd;
  assign claim    = hit_q & ~(addr_err & resp_en);
  assign par_fwd  = par_q;

endmodule

// File: rtl/prb_err_out.sv
module prb_err_out (
  input  logic clk,
  input  logic rst_n,
  input  logic pri_addr_err,
  input  logic sec_addr_err,
  input  logic pri_data_err,
  input  logic sec_data_err,
  input  logic cmd_perr_resp,
  input  logic cmd_serr_en,
  input  logic brg_perr_resp,
  output logic pri_perr_n,
  output logic sec_perr_n,
  output logic pri_serr_n,
  output logic serr_evt
);

  logic pperr_q, pperr_d;
  logic sperr_q, sperr_d;
  logic serr_q,  serr_d;

  always_comb begin
    serr_evt = cmd_serr_en &
               ((pri_addr_err & cmd_perr_resp) | (sec_addr_err & brg_perr_resp));
    pperr_d  = ~(pri_data_err & cmd_perr_resp);
    sperr_d  = ~(sec_data_err & brg_perr_resp);
    serr_d   = ~serr_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pperr_q <= 1'b1;
      sperr_q <= 1'b1;
      serr_q  <= 1'b1;
    end else begin
      pperr_q <= pperr_d;
      sperr_q <= sperr_d;
      serr_q  <= serr_d;
    end
  end

  assign pri_perr_n = pperr_q;
  assign sec_perr_n = sperr_q;
  assign pri_serr_n = serr_q;

endmodule

// File: rtl/prb_regs.sv
module prb_regs
  import prb_pkg::*;
#(
  parameter int RD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [RD_W-1:0]   reg_wdata,
  input  logic              pri_evt,
  input  logic              sec_evt,
  input  logic              serr_evt,
  output logic [RD_W-1:0]   reg_rdata,
  output logic              cmd_perr_resp,
  output logic              cmd_serr_en,
  output logic              brg_perr_resp,
  output logic              pri_det_par,
  output logic              sec_det_par,
  output logic              sig_serr
);

  logic cresp_q, cresp_d;
  logic serren_q, serren_d;
  logic bresp_q, bresp_d;
  logic pdet_q, pdet_d;
  logic sdet_q, sdet_d;
  logic sig_q, sig_d;
  logic wr_cmd, wr_bctl, wr_pst, wr_sst;
  logic wdata_unused;

  assign wdata_unused = ^reg_wdata[RD_W-1:2];

  always_comb begin
    wr_cmd  = reg_we && (reg_addr_e'(reg_addr) == RA_CMD);
    wr_bctl = reg_we && (reg_addr_e'(reg_addr) == RA_BCTL);
    wr_pst  = reg_we && (reg_addr_e'(reg_addr) == RA_PSTAT);
    wr_sst  = reg_we && (reg_addr_e'(reg_addr) == RA_SSTAT);

    cresp_d  = cresp_q;
    serren_d = serren_q;
    bresp_d  = bresp_q;
    if (wr_cmd) begin
      cresp_d  = reg_wdata[CMD_RESP_BIT];
      serren_d = reg_wdata[CMD_SERR_BIT];
    end
    if (wr_bctl) begin
      bresp_d = reg_wdata[BCTL_RESP_BIT];
    end

    // write-one-to-clear first, a new event in the same clock wins
    pdet_d = pdet_q;
    sig_d  = sig_q;
    sdet_d = sdet_q;
    if (wr_pst && reg_wdata[STAT_DET_BIT]) pdet_d = 1'b0;
    if (wr_pst && reg_wdata[STAT_SIG_BIT]) sig_d  = 1'b0;
    if (wr_sst && reg_wdata[STAT_DET_BIT]) sdet_d = 1'b0;
    if (pri_evt)  pdet_d = 1'b1;
    if (sec_evt)  sdet_d = 1'b1;
    if (serr_evt) sig_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cresp_q  <= 1'b0;
      serren_q <= 1'b0;
      bresp_q  <= 1'b0;
      pdet_q   <= 1'b0;
      sdet_q   <= 1'b0;
      sig_q    <= 1'b0;
    end else begin
      cresp_q  <= cresp_d;
      serren_q <= serren_d;
      bresp_q  <= bresp_d;
      pdet_q   <= pdet_d;
      sdet_q   <= sdet_d;
      sig_q    <= sig_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr_e'(reg_addr))
      RA_CMD: begin
        reg_rdata[CMD_RESP_BIT] = cresp_q;
        reg_rdata[CMD_SERR_BIT] = serren_q;
      end
      RA_BCTL:  reg_rdata[BCTL_RESP_BIT] = bresp_q;
      RA_PSTAT: begin
        reg_rdata[STAT_DET_BIT] = pdet_q;
        reg_rdata[STAT_SIG_BIT] = sig_q;
      end
      RA_SSTAT: reg_rdata[STAT_DET_BIT] = sdet_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign cmd_perr_resp = cresp_q;
  assign cmd_serr_en   = serren_q;
  assign brg_perr_resp = bresp_q;
  assign pri_det_par   = pdet_q;
  assign sec_det_par   = sdet_q;
  assign sig_serr      = sig_q;

endmodule

// File: rtl/prb_parity_responder.sv
module prb_parity_responder
  import prb_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4,
  parameter int RD_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pri_addr_phase,
  input  logic             pri_wr_phase,
  input  logic [AD_W-1:0]  pri_ad,
  input  logic [CBE_W-1:0] pri_cbe_n,
  input  logic             pri_par,
  input  logic             pri_dec_hit,
  input  logic             sec_addr_phase,
  input  logic             sec_wr_phase,
  input  logic [AD_W-1:0]  sec_ad,
  input  logic [CBE_W-1:0] sec_cbe_n,
  input  logic             sec_par,
  input  logic             sec_dec_hit,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [RD_W-1:0]  reg_wdata,
  output logic [RD_W-1:0]  reg_rdata,
  output logic             pri_claim,
  output logic             sec_claim,
  output logic             pri_perr_n,
  output logic             sec_perr_n,
  output logic             pri_serr_n,
  output logic             sec_par_out,
  output logic             pri_par_out
);

  logic [AD_W-1:0]  ad_a  [NSIDE];
  logic [CBE_W-1:0] cbe_a [NSIDE];
  logic [NSIDE-1:0] aph_a, wph_a, par_a, hit_a, resp_a;
  logic [NSIDE-1:0] aerr_a, derr_a, claim_a, fwd_a;

  logic pri_addr_err, sec_addr_err, pri_data_err, sec_data_err;
  logic cmd_perr_resp, cmd_serr_en, brg_perr_resp;
  logic pri_det_par, sec_det_par, sig_serr;
  logic serr_evt;

  assign ad_a[SIDE_PRI]  = pri_ad;
  assign ad_a[SIDE_SEC]  = sec_ad;
  assign cbe_a[SIDE_PRI] = pri_cbe_n;
  assign cbe_a[SIDE_SEC] = sec_cbe_n;
  assign aph_a  = {sec_addr_phase, pri_addr_phase};
  assign wph_a  = {sec_wr_phase, pri_wr_phase};
  assign par_a  = {sec_par, pri_par};
  assign hit_a  = {sec_dec_hit, pri_dec_hit};
  assign resp_a = {brg_perr_resp, cmd_perr_resp};

  generate
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
      prb_side_check #(
        .AD_W  (AD_W),
        .CBE_W (CBE_W)
      ) u_side (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_phase (aph_a[s]),
        .wr_phase   (wph_a[s]),
        .ad         (ad_a[s]),
        .cbe_n      (cbe_a[s]),
        .par        (par_a[s]),
        .dec_hit    (hit_a[s]),
        .resp_en    (resp_a[s]),
        .addr_err   (aerr_a[s]),
        .data_err   (derr_a[s]),
        .claim      (claim_a[s]),
        .par_fwd    (fwd_a[s])
      );
    end
  endgenerate

  assign pri_addr_err = aerr_a[SIDE_PRI];
  assign sec_addr_err = aerr_a[SIDE_SEC];
  assign pri_data_err = derr_a[SIDE_PRI];
  assign sec_data_err = derr_a[SIDE_SEC];
  assign pri_claim    = claim_a[SIDE_PRI];
  assign sec_claim    = claim_a[SIDE_SEC];
  // each side's PAR is carried, unmodified, to the opposite side
  assign sec_par_out  = fwd_a[SIDE_PRI];
  assign pri_par_out  = fwd_a[SIDE_SEC];

  prb_err_out u_err (
    .clk           (clk),
    .rst_n         (rst_n),
    .pri_addr_err  (pri_addr_err),
    .sec_addr_err  (sec_addr_err),
    .pri_data_err  (pri_data_err),
    .sec_data_err  (sec_data_err),
    .cmd_perr_resp (cmd_perr_resp),
    .cmd_serr_en   (cmd_serr_en),
    .brg_perr_resp (brg_perr_resp),
    .pri_perr_n    (pri_perr_n),
    .sec_perr_n    (sec_perr_n),
    .pri_serr_n    (pri_serr_n),
    .serr_evt      (serr_evt)
  );

  prb_regs #(
    .RD_W (RD_W)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .pri_evt       (pri_addr_err | pri_data_err),
    .sec_evt       (sec_addr_err | sec_data_err),
    .serr_evt      (serr_evt),
    .reg_rdata     (reg_rdata),
    .cmd_perr_resp (cmd_perr_resp),
    .cmd_serr_en   (cmd_serr_en),
    .brg_perr_resp (brg_perr_resp),
    .pri_det_par   (pri_det_par),
    .sec_det_par   (sec_det_par),
    .sig_serr      (sig_serr)
  );

endmodule

// File: rtl/prb_parity_responder_chk.sv
module prb_parity_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic pri_addr_err,
  input logic sec_addr_err,
  input logic pri_data_err,
  input logic sec_data_err,
  input logic cmd_perr_resp,
  input logic cmd_serr_en,
  input logic brg_perr_resp,
  input logic pri_det_par,
  input logic sec_det_par,
  input logic pri_claim,
  input logic sec_claim,
  input logic pri_perr_n,
  input logic sec_perr_n,
  input logic pri_serr_n
);

  assert_claim_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_addr_err && cmd_perr_resp) |-> !pri_claim);

  assert_claim_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_addr_err && brg_perr_resp) |-> !sec_claim);

  assert_det_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_addr_err || pri_data_err) |=> pri_det_par);

  assert_sec_det_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_addr_err || sec_data_err) |=> sec_det_par);

  assert_serr_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_serr_n |-> $past(cmd_serr_en));

  assert_serr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_serr_n |-> $past(pri_addr_err || sec_addr_err));

  assert_perr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_perr_n |-> $past(pri_data_err && cmd_perr_resp));

  assert_sec_perr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_perr_n |-> $past(sec_data_err && brg_perr_resp));

endmodule

bind prb_parity_responder prb_parity_responder_chk u_prb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pri_addr_err  (pri_addr_err),
  .sec_addr_err  (sec_addr_err),
  .pri_data_err  (pri_data_err),
  .sec_data_err  (sec_data_err),
  .cmd_perr_resp (cmd_perr_resp),
  .cmd_serr_en   (cmd_serr_en),
  .brg_perr_resp (brg_perr_resp),
  .pri_det_par   (pri_det_par),
  .sec_det_par   (sec_det_par),
  .pri_claim     (pri_claim),
  .sec_claim     (sec_claim),
  .pri_perr_n    (pri_perr_n),
  .sec_perr_n    (sec_perr_n),
  .pri_serr_n    (pri_serr_n)
);

// File: tb/test_prb_parity_responder.sv
`timescale 1ns/1ps
module test_prb_parity_responder;

  localparam int AD_W  = 32;
  localparam int CBE_W = 4;
  localparam int RD_W  = 8;

  localparam int SIG_PCLM  = 0;
  localparam int SIG_SCLM  = 1;
  localparam int SIG_PPERR = 2;
  localparam int SIG_SPERR = 3;
  localparam int SIG_SERR  = 4;
  localparam int SIG_SFWD  = 5;
  localparam int SIG_PFWD  = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic pri_addr_phase, pri_wr_phase, pri_par, pri_dec_hit;
  logic sec_addr_phase, sec_wr_phase, sec_par, sec_dec_hit;
  logic [AD_W-1:0]  pri_ad, sec_ad;
  logic [CBE_W-1:0] pri_cbe_n, sec_cbe_n;
  logic             reg_we;
  logic [1:0]       reg_addr;
  logic [RD_W-1:0]  reg_wdata, reg_rdata;
  logic pri_claim, sec_claim, pri_perr_n, sec_perr_n, pri_serr_n;
  logic sec_par_out, pri_par_out;

  always #2 clk = ~clk;

  prb_parity_responder #(.AD_W(AD_W), .CBE_W(CBE_W), .RD_W(RD_W)) i_prb_parity_responder (
    .clk(clk), .rst_n(rst_n),
    .pri_addr_phase(pri_addr_phase), .pri_wr_phase(pri_wr_phase), .pri_ad(pri_ad),
    .pri_cbe_n(pri_cbe_n), .pri_par(pri_par), .pri_dec_hit(pri_dec_hit),
    .sec_addr_phase(sec_addr_phase), .sec_wr_phase(sec_wr_phase), .sec_ad(sec_ad),
    .sec_cbe_n(sec_cbe_n), .sec_par(sec_par), .sec_dec_hit(sec_dec_hit),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pri_claim(pri_claim), .sec_claim(sec_claim), .pri_perr_n(pri_perr_n),
    .sec_perr_n(sec_perr_n), .pri_serr_n(pri_serr_n),
    .sec_par_out(sec_par_out), .pri_par_out(pri_par_out)
  );

  typedef struct {
    int    cyc;
    int    sig;
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  // bench model of the register contents
  bit m_cmd, m_serr, m_brg, m_pdet, m_sdet, m_sig;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic sig_val(input int s);
    case (s)
      SIG_PCLM:  return pri_claim;
      SIG_SCLM:  return sec_claim;
      SIG_PPERR: return pri_perr_n;
      SIG_SPERR: return sec_perr_n;
      SIG_SERR:  return pri_serr_n;
      SIG_SFWD:  return sec_par_out;
      default:   return pri_par_out;
    endcase
  endfunction

  // monitor: pops expected items when their cycle comes up
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.cyc < cyc) chk({it.tag, " missed"}, 32'd0, 32'd1);
      else              chk(it.tag, {31'd0, sig_val(it.sig)}, {31'd0, it.exp});
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    tick();
    reg_we    = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(tag, {24'd0, reg_rdata}, {24'd0, exp});
    tick();
  endtask

  task automatic set_cfg(input bit cr, input bit se, input bit br);
    wr_reg(2'd0, {6'd0, se, cr});
    wr_reg(2'd1, {7'd0, br});
    m_cmd = cr; m_serr = se; m_brg = br;
  endtask

  task automatic clear_status();
    wr_reg(2'd2, 8'h03);
    wr_reg(2'd3, 8'h01);
    m_pdet = 0; m_sdet = 0; m_sig = 0;
  endtask

  // driver: one phase on either or both sides, PAR on the next clock
  task automatic phase(input bit p_on, input bit s_on, input bit is_addr,
                       input bit bad_p, input bit bad_s, input bit hit,
                       input logic [31:0] ad, input logic [3:0] cbe,
                       input bit mid_we, input logic [1:0] mid_a, input logic [7:0] mid_d);
    int n;
    bit ep, es, sev;
    logic pp, sp;
    n = cyc;
    pri_ad = ad;  pri_cbe_n = cbe;
    sec_ad = ~ad; sec_cbe_n = ~cbe;
    pri_addr_phase = p_on & is_addr;  pri_wr_phase = p_on & !is_addr;
    sec_addr_phase = s_on & is_addr;  sec_wr_phase = s_on & !is_addr;
    pri_dec_hit = p_on & hit;         sec_dec_hit = s_on & hit;
    tick();
    pri_addr_phase = 0; pri_wr_phase = 0; pri_dec_hit = 0;
    sec_addr_phase = 0; sec_wr_phase = 0; sec_dec_hit = 0;
    pp = (^{ad, cbe}) ^ bad_p;
    sp = (^{~ad, ~cbe}) ^ bad_s;
    pri_par = pp; sec_par = sp;
    pri_ad = $urandom; sec_ad = $urandom;
    pri_cbe_n = 4'($urandom); sec_cbe_n = 4'($urandom);
    if (mid_we) begin
      reg_we = 1'b1; reg_addr = mid_a; reg_wdata = mid_d;
    end
    ep  = p_on & bad_p;
    es  = s_on & bad_s;
    sev = m_serr & is_addr & ((ep & m_cmd) | (es & m_brg));
    // R2 R3: claim decision in the PAR clock
    q.push_back('{n+1, SIG_PCLM, p_on & is_addr & hit & !(ep & m_cmd), "R2 pri claim"});
    q.push_back('{n+1, SIG_SCLM, s_on & is_addr & hit & !(es & m_brg), "R3 sec claim"});
    // R5 R6 R7 R10 R11: registered responses two clocks after the phase
    q.push_back('{n+2, SIG_SERR,  !sev, "R5/R6 serr"});
    q.push_back('{n+2, SIG_PPERR, !(ep & !is_addr & m_cmd), "R7/R11 pri perr"});
    q.push_back('{n+2, SIG_SPERR, !(es & !is_addr & m_brg), "R7/R11 sec perr"});
    q.push_back('{n+2, SIG_SFWD, pp, "R10 pri par to sec"});
    q.push_back('{n+2, SIG_PFWD, sp, "R10 sec par to pri"});
    q.push_back('{n+3, SIG_SERR,  1'b1, "R5/R6 serr one clock"});
    q.push_back('{n+3, SIG_PPERR, 1'b1, "R7 pri perr one clock"});
    q.push_back('{n+3, SIG_SPERR, 1'b1, "R7 sec perr one clock"});
    // model update: the register write first, then the events (events win)
    if (mid_we) begin
      case (mid_a)
        2'd0: begin m_cmd = mid_d[0]; m_serr = mid_d[1]; end
        2'd1: m_brg = mid_d[0];
        2'd2: begin
          if (mid_d[0]) m_pdet = 0;
          if (mid_d[1]) m_sig = 0;
        end
        default: if (mid_d[0]) m_sdet = 0;
      endcase
    end
    if (ep)  m_pdet = 1;
    if (es)  m_sdet = 1;
    if (sev) m_sig  = 1;
    tick();
    reg_we = 1'b0;
  endtask

  initial begin
    rst_n = 0;
    pri_addr_phase = 0; pri_wr_phase = 0; pri_par = 0; pri_dec_hit = 0;
    sec_addr_phase = 0; sec_wr_phase = 0; sec_par = 0; sec_dec_hit = 0;
    pri_ad = '0; sec_ad = '0; pri_cbe_n = '0; sec_cbe_n = '0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    {m_cmd, m_serr, m_brg, m_pdet, m_sdet, m_sig} = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1: reset state
    @(negedge clk);
    chk("R1 pri_claim", {31'd0, pri_claim}, 32'd0);
    chk("R1 sec_claim", {31'd0, sec_claim}, 32'd0);
    chk("R1 pri_perr_n", {31'd0, pri_perr_n}, 32'd1);
    chk("R1 sec_perr_n", {31'd0, sec_perr_n}, 32'd1);
    chk("R1 pri_serr_n", {31'd0, pri_serr_n}, 32'd1);
    tick();
    for (int a = 0; a < 4; a++) rd_chk(2'(a), 8'd0, "R1 register reset");

    // all enable combinations, both sides, address and write data, good and bad
    for (int se = 0; se < 2; se++)
      for (int cr = 0; cr < 2; cr++)
        for (int br = 0; br < 2; br++)
          for (int sd = 0; sd < 2; sd++)
            for (int kd = 0; kd < 2; kd++)
              for (int bd = 0; bd < 2; bd++) begin
                set_cfg(cr[0], se[0], br[0]);
                phase(sd == 0, sd == 1, kd == 0, bd[0], bd[0],
                      ((se + cr + br + sd) % 3) != 0,
                      $urandom, 4'($urandom), 1'b0, 2'd0, 8'd0);
                rd_chk(2'd2, {6'd0, m_sig, m_pdet}, "R4 R5 R6 pri status");
                rd_chk(2'd3, {7'd0, m_sdet}, "R4 sec status");
                clear_status();
              end

    // R6: faults on both sides together give one pulse
    set_cfg(1, 1, 1);
    phase(1, 1, 1, 1, 1, 1, 32'hA5A5_0F0F, 4'h6, 1'b0, 2'd0, 8'd0);
    rd_chk(2'd2, 8'h03, "R6 both sides pri status");
    rd_chk(2'd3, 8'h01, "R6 both sides sec status");
    clear_status();

    // R8: clear and new error in the same clock, then partial clears
    phase(1, 0, 1, 1, 0, 1, 32'h1234_5678, 4'h3, 1'b1, 2'd2, 8'h03);
    rd_chk(2'd2, 8'h03, "R8 set wins over clear");
    wr_reg(2'd2, 8'h00);
    rd_chk(2'd2, 8'h03, "R8 zero write keeps bits");
    wr_reg(2'd2, 8'h02);
    rd_chk(2'd2, 8'h01, "R8 clear signaled only");
    wr_reg(2'd2, 8'h01);
    rd_chk(2'd2, 8'h00, "R8 clear detected");
    clear_status();

    // R9: register write during data parity error detection
    set_cfg(1, 0, 0);
    phase(1, 0, 0, 1, 0, 1, 32'hDEAD_BEEF, 4'h0, 1'b1, 2'd0, 8'h02);
    rd_chk(2'd0, 8'h02, "R9 command write landed");
    rd_chk(2'd2, {6'd0, m_sig, m_pdet}, "R9 detected bit");
    clear_status();

    // R11: bad parity with no phase strobes
    set_cfg(1, 1, 1);
    phase(0, 0, 1, 1, 1, 1, 32'h0000_0001, 4'h0, 1'b0, 2'd0, 8'd0);
    phase(0, 0, 0, 1, 1, 1, 32'h8000_0000, 4'hF, 1'b0, 2'd0, 8'd0);
    rd_chk(2'd2, 8'h00, "R11 pri status untouched");
    rd_chk(2'd3, 8'h00, "R11 sec status untouched");

    repeat (4) tick();
    if (q.size() != 0) chk("R1 scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog R1: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

endmodule